// File: doc/BRIEF.md
# Peripheral Bus Master Bridge

This block turns single commands from a system-side requester into transfers on a simple peripheral bus that has no wait states. The requester presents a valid flag, a direction flag, an address and write data. A transfer takes exactly one setup cycle and then exactly one enable cycle. The bridge then returns a one-clock completion pulse. For reads, that pulse carries the data sampled from the peripheral.

The upper bits of the address choose one of several peripheral regions. Each region owns one select line. A request that falls outside every region never reaches the bus. It is completed at once with zero data.

While a transfer is in its setup cycle, the requester sees a busy flag. A new request can be taken during the enable cycle, so transfers can run back to back without an idle cycle between them. After a transfer, the bus address and direction keep their values, so no lines toggle needlessly between accesses.

Top module: `pbus_bridge`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, every select line, the enable strobe, the completion pulse and the busy flag are low.
- R2: The cycle after a mapped request is accepted is a setup cycle. Exactly one select line is high and the enable strobe is low.
- R3: A setup cycle lasts one clock and is always followed by an enable cycle. In the enable cycle the same select line stays high and the enable strobe is high.
- R4: Bus address, direction, write data and selects do not change between the setup cycle and the enable cycle.
- R5: For a read, the peripheral's data is captured at the edge that ends the enable cycle. It appears on the response data together with a completion pulse that lasts exactly one clock.
- R6: A write completes with the same one-clock completion pulse, and its response data is zero.
- R7: The region field is the top 4 address bits. A value k below the region count raises select bit k, and the bus address equals the request address.
- R8: A request whose region field is not below the region count raises no select line and leaves the bus address unchanged. It completes with a pulse in the next cycle and zero response data.
- R9: The busy flag is high throughout a setup cycle, and a request offered then is not accepted.
- R10: A mapped request offered during an enable cycle is accepted at the end of that cycle. The next cycle is a setup cycle for it, and the earlier transfer's completion pulse is high in that same cycle.
- R11: Once a transfer has finished, the bus address and direction keep their values while the bridge is idle.
- R12: An unmapped request offered during an enable cycle is held off with busy. It is accepted in the idle cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester offers a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Command write data |
| req_busy | output | 1 | Command cannot be taken this cycle |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data (zero for writes and unmapped) |
| p_addr | output | ADDR_W | Peripheral bus address |
| p_sel | output | NSLV | One-hot peripheral selects |
| p_en | output | 1 | Enable strobe |
| p_write | output | 1 | Peripheral bus direction |
| p_wdata | output | DATA_W | Peripheral bus write data |
| p_rdata | input | DATA_W | Data returned by the selected peripheral |

## Verification
The assertions assume that the requester follows a valid/busy handshake. A command is counted as taken only on an edge where valid is high and busy is low. A requester that drops or changes its command while busy would break the acceptance-based properties.

The bench always holds a command steady until it sees busy low, then withdraws it one cycle later. It drives peripheral read data only during the enable cycle. It also offers mapped and unmapped commands in the idle, setup and enable cycles, so that every acceptance window is visited.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    PB_IDLE   = 2'd0,
    PB_SETUP  = 2'd1,
    PB_ENABLE = 2'd2
  } pb_state_e;
endpackage

// File: rtl/pbus_decode.sv
module pbus_decode #(
  parameter int NSLV  = 4,
  parameter int RGN_W = 4
) (
  input  logic [RGN_W-1:0] rgn,
  output logic [NSLV-1:0]  sel_oh,
  output logic             hit
);
  // one comparator per region
  for (genvar i = 0; i < NSLV; i++) begin : g_rgn
    assign sel_oh[i] = (rgn == RGN_W'(i));
  end
  assign hit = |sel_oh;
endmodule

// File: rtl/pbus_fsm.sv
module pbus_fsm
  import pbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  output pb_state_e state
);
  pb_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      PB_IDLE:   state_nx = start ? PB_SETUP : PB_IDLE;
      PB_SETUP:  state_nx = PB_ENABLE;
      PB_ENABLE: state_nx = start ? PB_SETUP : PB_IDLE;
      default:   state_nx = PB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PB_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NSLV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              miss,
  input  logic              in_enable,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NSLV-1:0]   sel_oh,
  input  logic [DATA_W-1:0] p_rdata,
  output logic [ADDR_W-1:0] p_addr,
  output logic              p_write,
  output logic [DATA_W-1:0] p_wdata,
  output logic [NSLV-1:0]   sel_r,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic ld_wdata;
  logic finish;

  assign ld_wdata = start && req_write;
  assign finish   = in_enable || miss;

  // bus-side holding registers: loaded only when a mapped transfer starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_addr  <= '0;
      p_write <= 1'b0;
      sel_r   <= '0;
    end else if (start) begin
      p_addr  <= req_addr;
      p_write <= req_write;
      sel_r   <= sel_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        p_wdata <= '0;
    else if (ld_wdata) p_wdata <= req_wdata;
  end

  // response side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_done <= 1'b0;
    else        rsp_done <= finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (finish) rsp_rdata <= (in_enable && !p_write) ? p_rdata : '0;
  end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NSLV   = 4,
  parameter int RGN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] p_addr,
  output logic [NSLV-1:0]   p_sel,
  output logic              p_en,
  output logic              p_write,
  output logic [DATA_W-1:0] p_wdata,
  input  logic [DATA_W-1:0] p_rdata
);
  localparam int RGN_LSB = ADDR_W - RGN_W;

  pb_state_e       state;
  logic [NSLV-1:0] sel_oh;
  logic [NSLV-1:0] sel_r;
  logic            hit;
  logic            window;
  logic            accept;
  logic            start;
  logic            miss;
  logic            in_enable;

  pbus_decode #(.NSLV(NSLV), .RGN_W(RGN_W)) u_dec (
    .rgn    (req_addr[ADDR_W-1:RGN_LSB]),
    .sel_oh (sel_oh),
    .hit    (hit)
  );

  // idle takes anything; enable takes only mapped commands
  assign in_enable = (state == PB_ENABLE);
  assign window    = (state == PB_IDLE) || (in_enable && hit);
  assign req_busy  = rst_n ? !window : 1'b0;
  assign accept    = req_valid && window;
  assign start     = accept && hit;
  assign miss      = accept && !hit;

  pbus_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .state (state)
  );

  pbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLV(NSLV)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .miss      (miss),
    .in_enable (in_enable),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sel_oh    (sel_oh),
    .p_rdata   (p_rdata),
    .p_addr    (p_addr),
    .p_write   (p_write),
    .p_wdata   (p_wdata),
    .sel_r     (sel_r),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  assign p_sel = (state == PB_IDLE) ? '0 : sel_r;
  assign p_en  = in_enable;
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NSLV   = 4,
  parameter int RGN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_busy,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] p_addr,
  input logic [NSLV-1:0]   p_sel,
  input logic              p_en,
  input logic              p_write,
  input logic [DATA_W-1:0] p_wdata
);
  logic in_setup;
  logic took;
  logic unmapped;

  assign in_setup = (|p_sel) && !p_en;
  assign took     = req_valid && !req_busy;
  assign unmapped = int'(req_addr[ADDR_W-1:ADDR_W-RGN_W]) >= NSLV;

  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_sel));

  a_r3_enable_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
    p_en |-> $countones(p_sel) == 1);

  a_r3_setup_to_enable: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |=> (p_en && p_sel == $past(p_sel)));

  a_r4_stable_bus: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |=> ($stable(p_addr) && $stable(p_write) && $stable(p_wdata)));

  a_r5_done_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    p_en |=> rsp_done);

  a_r5_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_en && !took) |=> !rsp_done);

  a_r9_busy_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |-> req_busy);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (p_sel == '0 && !took) |=> ($stable(p_addr) && $stable(p_write)));

  a_r12_miss_held_in_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (p_en && req_valid && unmapped) |-> req_busy);
endmodule

bind pbus_bridge pbus_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLV(NSLV), .RGN_W(RGN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_busy  (req_busy),
  .rsp_done  (rsp_done),
  .p_addr    (p_addr),
  .p_sel     (p_sel),
  .p_en      (p_en),
  .p_write   (p_write),
  .p_wdata   (p_wdata)
);

// File: tb/pbus_bridge_bench.sv
`timescale 1ns/1ps
module pbus_bridge_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NSLV   = 4;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              req_busy;
  logic              rsp_done;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] p_addr;
  logic [NSLV-1:0]   p_sel;
  logic              p_en;
  logic              p_write;
  logic [DATA_W-1:0] p_wdata;
  logic [DATA_W-1:0] p_rdata;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  pbus_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLV(NSLV)) u_pbus_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_busy(req_busy),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .p_addr(p_addr), .p_sel(p_sel),
    .p_en(p_en), .p_write(p_write), .p_wdata(p_wdata), .p_rdata(p_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // offer a command at a negedge, hold it until busy is low, withdraw after accept;
  // returns at the negedge one cycle after the accepting edge
  task automatic offer(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (req_busy) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(p_sel == '0, "R1 sel in reset", 64'(p_sel), 0);
    chk(!p_en, "R1 enable in reset", 64'(p_en), 0);
    chk(!rsp_done, "R1 done in reset", 64'(rsp_done), 0);
    chk(!req_busy, "R1 busy in reset", 64'(req_busy), 0);
  endtask

  task automatic t_read(input int k, input logic [11:0] off, input logic [DATA_W-1:0] d);
    logic [ADDR_W-1:0] a;
    a = {4'(k), off};
    offer(1'b0, a, '0);
    chk(p_sel == NSLV'(1 << k), "R2 R7 setup select", 64'(p_sel), 64'(1 << k));
    chk(!p_en, "R2 setup enable low", 64'(p_en), 0);
    chk(p_addr == a, "R7 bus address", 64'(p_addr), 64'(a));
    @(negedge clk); p_rdata = d; #1;
    chk(p_en && p_sel == NSLV'(1 << k), "R3 enable cycle", 64'({p_en, p_sel}),
        64'({1'b1, NSLV'(1 << k)}));
    chk(p_addr == a && !p_write, "R4 address and direction stable", 64'(p_addr), 64'(a));
    @(negedge clk); p_rdata = '1; #1;
    chk(rsp_done, "R5 done pulse", 64'(rsp_done), 1);
    chk(rsp_rdata == d, "R5 read data", 64'(rsp_rdata), 64'(d));
    @(negedge clk); #1;
    chk(!rsp_done, "R5 pulse one clock", 64'(rsp_done), 0);
    chk(p_addr == a && !p_write && p_sel == '0, "R11 idle hold after read", 64'(p_addr), 64'(a));
  endtask

  task automatic t_write(input int k, input logic [11:0] off, input logic [DATA_W-1:0] d);
    logic [ADDR_W-1:0] a;
    a = {4'(k), off};
    offer(1'b1, a, d);
    chk(p_wdata == d && p_write, "R2 write setup data", 64'(p_wdata), 64'(d));
    @(negedge clk); #1;
    chk(p_en && p_wdata == d && p_addr == a, "R4 write data stable", 64'(p_wdata), 64'(d));
    @(negedge clk); #1;
    chk(rsp_done && rsp_rdata == '0, "R6 write done zero data", 64'(rsp_rdata), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(p_addr == a && p_write, "R11 idle hold after write", 64'({p_write, p_addr}),
        64'({1'b1, a}));
  endtask

  task automatic t_busy_b2b();
    offer(1'b0, 16'h1040, '0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h3080; req_wdata = 32'hCAFE0001;
    #1;
    chk(req_busy, "R9 busy in setup", 64'(req_busy), 1);
    @(negedge clk); p_rdata = 32'h0000BEEF; #1;
    chk(p_en && p_sel == 4'b0010, "R9 setup request not taken", 64'(p_sel), 64'h2);
    chk(!req_busy, "R10 enable takes mapped", 64'(req_busy), 0);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(!p_en && p_sel == 4'b1000, "R10 straight to setup", 64'({p_en, p_sel}), 64'h8);
    chk(rsp_done && rsp_rdata == 32'h0000BEEF, "R10 earlier done", 64'(rsp_rdata), 64'hBEEF);
    @(negedge clk); #1;
    chk(p_en && p_wdata == 32'hCAFE0001, "R10 second enable", 64'(p_wdata), 64'hCAFE0001);
    @(negedge clk); #1;
    chk(rsp_done && p_sel == '0, "R10 second done", 64'(rsp_done), 1);
  endtask

  task automatic t_miss();
    logic [ADDR_W-1:0] held;
    held = p_addr;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h9123;
    #1;
    chk(!req_busy, "R8 idle takes unmapped", 64'(req_busy), 0);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(p_sel == '0 && !p_en, "R8 no select", 64'(p_sel), 0);
    chk(rsp_done && rsp_rdata == '0, "R8 done with zero", 64'(rsp_rdata), 0);
    chk(p_addr == held, "R8 address untouched", 64'(p_addr), 64'(held));
  endtask

  task automatic t_miss_in_enable();
    offer(1'b0, 16'h2010, '0);
    @(negedge clk);
    p_rdata = 32'h12345678;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hF000;
    #1;
    chk(req_busy, "R12 unmapped held in enable", 64'(req_busy), 1);
    @(negedge clk); #1;
    chk(rsp_done && rsp_rdata == 32'h12345678, "R12 first completes", 64'(rsp_rdata),
        64'h12345678);
    chk(!req_busy && p_sel == '0, "R12 taken in idle", 64'(req_busy), 0);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(rsp_done && rsp_rdata == '0 && p_sel == '0, "R12 unmapped done", 64'(rsp_rdata), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; p_rdata = '0;
    repeat (2) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NSLV; k++) t_read(k, 12'(16 * k + 4), 32'hA5000000 + 32'(k));
    t_write(2, 12'h0FC, 32'h5A5A1234);
    t_write(0, 12'h004, 32'hFFFF0000);
    t_busy_b2b();
    t_read(1, 12'h100, 32'h87654321);
    t_miss();
    t_miss_in_enable();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule